// File: doc/BRIEF.md
# Interpolation Frame Strobe Generator

This block is the timing generator for one interpolating transmit channel. A frame counter runs on the main clock and wraps once per interpolation period. Each time it wraps, the block raises a frame strobe to ask the upstream source for a new input sample. The strobe stays high for one divided-clock period and then falls, and that falling edge marks the start of the input frame. A divided-clock enable pulses at every divided-clock boundary and is re-aligned to the frame at each wrap. A single-cycle capture pulse tells the input formatter when to latch the first word of the frame. That pulse comes a programmed number of divided-clock periods after the strobe rises.

Every channel gets its own instance, so channels share no state. All registers change on the rising edge of the main clock. The configuration inputs are meant to be changed only while reset is asserted. If the interpolation ratio is too short to contain the programmed delay, the block raises a configuration error and withholds the capture pulse.

Top module: `frame_strobe_gen`

## Requirements
- R1: While `rst_n` is low, `frame_strobe` and `first_capture` are 0, `div_clk_en` is 1, and all counters hold zero.
- R2: Let R be the effective ratio and k the number of rising clock edges since reset release. `frame_strobe` is 1 only when k >= R and (k mod R) < D, where D is the effective divide. The strobe therefore first rises R cycles after reset release and rises again every R cycles after that.
- R3: When D < R, each strobe lasts exactly D main-clock cycles and then falls. The fall happens where (k mod R) == D, and it marks the frame start.
- R4: `div_clk_en` is 1 exactly when ((k mod R) mod D) == 0. It pulses once every D cycles, and its phase restarts at every frame wrap.
- R5: `first_capture` is 1 exactly when k >= R and (k mod R) == D*delay, and no configuration error is present. For delay = 0 it coincides with the strobe rise.
- R6: `cfg_error` is 1 exactly when R < D*(delay+1). It follows the configuration inputs combinationally.
- R7: While `cfg_error` is 1, `first_capture` is never asserted.
- R8: An `interp_ratio` of 0 behaves as a ratio of 1, and a `clk_div` of 0 behaves as a divide of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| interp_ratio | input | RATIO_W | Interpolation period in main clocks (0 treated as 1) |
| clk_div | input | DIV_W | Divided-clock period in main clocks (0 treated as 1) |
| fs_delay | input | DLY_W | Strobe-to-first-capture delay in divided-clock periods |
| frame_strobe | output | 1 | Request for a new input sample; its falling edge marks frame start |
| div_clk_en | output | 1 | One-cycle enable at each divided-clock boundary |
| first_capture | output | 1 | One-cycle pulse to latch the first word of the frame |
| cfg_error | output | 1 | Ratio too short for the programmed divide and delay |

## Verification
The bench sweeps every combination of ratio 0 to 12, divide 0 to 4 and delay 0 to 3, with a reset before each one. Each setting runs for three frames and every output is compared every cycle against a model built from modular arithmetic. Ratios that equal the strobe width, or that fall short of the delay window, separate legal captures from suppressed ones. Zero settings show that they collapse to 1. Divides that do not divide the ratio evenly show whether the divided-clock phase really restarts at each frame wrap instead of free-running.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  // Main-clock offset within a frame where the first word is captured.
  function automatic int unsigned capture_offset(input int unsigned div_eff,
                                                 input int unsigned delay);
    return div_eff * delay;
  endfunction

  // The frame must hold the whole delay window plus one divided period.
  function automatic logic cfg_too_short(input int unsigned ratio_eff,
                                         input int unsigned div_eff,
                                         input int unsigned delay);
    return ratio_eff < (div_eff * (delay + 1));
  endfunction

endpackage

// File: rtl/fsg_frame_counter.sv
module fsg_frame_counter #(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_eff,
  output logic [RATIO_W-1:0] frame_cnt,
  output logic               frame_wrap,
  output logic               started
);

  assign frame_wrap = (frame_cnt >= (ratio_eff - RATIO_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_cnt <= '0;
      started   <= 1'b0;
    end else begin
      frame_cnt <= frame_wrap ? '0 : (frame_cnt + RATIO_W'(1));
      if (frame_wrap) started <= 1'b1;
    end
  end

endmodule

// File: rtl/fsg_div_phase.sv
module fsg_div_phase #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_eff,
  input  logic             frame_wrap,
  output logic             boundary
);

  logic [DIV_W-1:0] div_cnt;
  logic             div_last;

  assign div_last = (div_cnt >= (div_eff - DIV_W'(1)));
  assign boundary = (div_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      div_cnt <= '0;
    else if (frame_wrap || div_last) div_cnt <= '0;
    else                             div_cnt <= div_cnt + DIV_W'(1);
  end

endmodule

// File: rtl/fsg_event_decode.sv
module fsg_event_decode
  import fsg_pkg::*;
#(
  parameter int RATIO_W = 8,
  parameter int DIV_W   = 4,
  parameter int DLY_W   = 3
) (
  input  logic               started,
  input  logic [RATIO_W-1:0] frame_cnt,
  input  logic [DIV_W-1:0]   div_eff,
  input  logic [DLY_W-1:0]   fs_delay,
  input  logic               cfg_error,
  output logic               strobe,
  output logic               capture
);

  int unsigned pos;
  int unsigned width;
  int unsigned cap_at;

  always_comb begin
    pos     = 32'(frame_cnt);
    width   = 32'(div_eff);
    cap_at  = capture_offset(width, 32'(fs_delay));
    strobe  = started && (pos < width);
    capture = started && !cfg_error && (pos == cap_at);
  end

endmodule

// File: rtl/frame_strobe_gen.sv
module frame_strobe_gen
  import fsg_pkg::*;
#(
  parameter int RATIO_W = 8,
  parameter int DIV_W   = 4,
  parameter int DLY_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] interp_ratio,
  input  logic [DIV_W-1:0]   clk_div,
  input  logic [DLY_W-1:0]   fs_delay,
  output logic               frame_strobe,
  output logic               div_clk_en,
  output logic               first_capture,
  output logic               cfg_error
);

  logic [RATIO_W-1:0] ratio_eff;
  logic [DIV_W-1:0]   div_eff;
  logic [RATIO_W-1:0] frame_cnt;
  logic               frame_wrap;
  logic               started;

  // R8: zero settings collapse to one
  assign ratio_eff = (interp_ratio == '0) ? RATIO_W'(1) : interp_ratio;
  assign div_eff   = (clk_div == '0) ? DIV_W'(1) : clk_div;

  assign cfg_error = cfg_too_short(32'(ratio_eff), 32'(div_eff), 32'(fs_delay));

  fsg_frame_counter #(.RATIO_W(RATIO_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_eff (ratio_eff),
    .frame_cnt (frame_cnt),
    .frame_wrap(frame_wrap),
    .started   (started)
  );

  fsg_div_phase #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_eff   (div_eff),
    .frame_wrap(frame_wrap),
    .boundary  (div_clk_en)
  );

  fsg_event_decode #(.RATIO_W(RATIO_W), .DIV_W(DIV_W), .DLY_W(DLY_W)) u_dec (
    .started  (started),
    .frame_cnt(frame_cnt),
    .div_eff  (div_eff),
    .fs_delay (fs_delay),
    .cfg_error(cfg_error),
    .strobe   (frame_strobe),
    .capture  (first_capture)
  );

endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
  parameter int RATIO_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_strobe,
  input logic               div_clk_en,
  input logic               first_capture,
  input logic               cfg_error,
  input logic [RATIO_W-1:0] frame_cnt,
  input logic [RATIO_W-1:0] ratio_eff,
  input logic               started
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!frame_strobe && !first_capture && div_clk_en)); // R1

  AST_STROBE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> started); // R2

  AST_STROBE_RISES_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_strobe) |-> (frame_cnt == '0)); // R2

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt < ratio_eff); // R2

  AST_DIV_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_cnt == '0) |-> div_clk_en); // R4

  AST_NO_EARLY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !first_capture); // R5

  AST_ERROR_BLOCKS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> !first_capture); // R7

endmodule

bind frame_strobe_gen fsg_checker #(.RATIO_W(RATIO_W)) u_fsg_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_strobe (frame_strobe),
  .div_clk_en   (div_clk_en),
  .first_capture(first_capture),
  .cfg_error    (cfg_error),
  .frame_cnt    (frame_cnt),
  .ratio_eff    (ratio_eff),
  .started      (started)
);

// File: tb/frame_strobe_gen_bench.sv
module frame_strobe_gen_bench;

  localparam int RATIO_W = 8;
  localparam int DIV_W   = 4;
  localparam int DLY_W   = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [RATIO_W-1:0] interp_ratio = '0;
  logic [DIV_W-1:0]   clk_div = '0;
  logic [DLY_W-1:0]   fs_delay = '0;
  logic               frame_strobe, div_clk_en, first_capture, cfg_error;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  frame_strobe_gen #(.RATIO_W(RATIO_W), .DIV_W(DIV_W), .DLY_W(DLY_W)) u_frame_strobe_gen (
    .clk(clk), .rst_n(rst_n), .interp_ratio(interp_ratio), .clk_div(clk_div),
    .fs_delay(fs_delay), .frame_strobe(frame_strobe), .div_clk_en(div_clk_en),
    .first_capture(first_capture), .cfg_error(cfg_error)
  );

  task automatic check(input string req, input string what,
                       input logic actual, input logic expected);
    n_tests++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0b expected=%0b (ratio=%0d div=%0d dly=%0d)",
               req, what, actual, expected, interp_ratio, clk_div, fs_delay);
    end
  endtask

  task automatic run_config(input int ri, input int di, input int dl);
    int  re, de, k_end;
    bit  err;
    string zreq;
    re  = (ri == 0) ? 1 : ri;   // R8 model
    de  = (di == 0) ? 1 : di;
    err = (re < de * (dl + 1));
    zreq = (ri == 0 || di == 0) ? "R8" : "R2";
    @(negedge clk);
    rst_n        = 1'b0;
    interp_ratio = RATIO_W'(ri);
    clk_div      = DIV_W'(di);
    fs_delay     = DLY_W'(dl);
    @(negedge clk);
    @(negedge clk);
    check("R1", "strobe in reset", frame_strobe, 1'b0);
    check("R1", "capture in reset", first_capture, 1'b0);
    check("R1", "div enable in reset", div_clk_en, 1'b1);
    check("R6", "cfg_error", cfg_error, err);
    rst_n = 1'b1;
    k_end = 3 * re + 2;
    for (int k = 0; k <= k_end; k++) begin
      int  f;
      bit  st;
      f  = k % re;
      st = (k >= re);
      check(zreq, "strobe", frame_strobe, st && (f < de));
      if (de < re && st && f == de)
        check("R3", "strobe low at frame start", frame_strobe, 1'b0);
      check("R4", "div enable", div_clk_en, (f % de) == 0);
      if (err)
        check("R7", "capture under error", first_capture, 1'b0);
      else
        check("R5", "capture", first_capture, st && (f == de * dl));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int ri = 0; ri <= 12; ri++)
      for (int di = 0; di <= 4; di++)
        for (int dl = 0; dl <= 3; dl++)
          run_config(ri, di, dl);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule